// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a byte-wide serial port that sits on a 32-bit register bus. Software writes a byte to the data register to send it. The block shifts the byte out on `txd` as an 8N1 frame, least significant bit first. Incoming frames on `rxd` are deserialised. A good byte is latched into the same data word, where software reads it back.

Each direction has its own sticky event flag in the status register. The transmit flag is set once a frame's stop bit has fully left the line. The receive flag is set when a byte is latched. Software clears a flag by writing a one to it. While the receive flag is still set, the receiver refuses new bytes. A single level interrupt combines each flag with its own enable bit.

The bit period is 16 ticks of a prescaler that reloads from the divisor register. The bit period is therefore 16·(divisor+1) clock cycles. Two control bits are stored only and read back, with no effect: a pass-through enable and a break-debug enable.

Top module: `evt_uart`

## Requirements
- R1: After reset the data, divisor, control and debug words read 0. The status word reads 0x1. `irq` is low and `txd` is high.
- R2: The register is chosen by the byte address shifted right by two: word 0 data, word 1 divisor, word 2 status, word 3 control, word 4 debug. All accesses are full 32-bit words.
- R3: Status bit 0 (transmitter ready) always reads 1. Bit 1 is the receive event, bit 2 is the transmit event, and bits 31..3 read 0.
- R4: The divisor, control and debug words keep all 32 written bits and read them back unchanged. Control bit 2 and debug bit 0 have no effect on `txd`, `irq` or reception.
- R5: `irq` is high exactly when (receive event and control bit 0) or (transmit event and control bit 1). It follows a register write or reception one clock later.
- R6: A status write clears bit 1 and/or bit 2 where the written value has a one. Ones written elsewhere are ignored, and bit 0 stays 1.
- R7: A data write while the transmitter is idle sends the low 8 bits as start (0), 8 data bits LSB first, and stop (1). Each bit lasts 16·(divisor+1) clocks. The line idles high.
- R8: The transmit event is not set by the write itself. It is set when the stop bit period ends.
- R9: A data write made while a frame is still being sent is discarded. Only the first byte appears on the line.
- R10: A frame whose start bit is still low at mid-bit and whose stop bit samples high loads its byte into the data word and sets the receive event.
- R11: A frame that completes while the receive event is set is dropped. The data word and the status stay unchanged.
- R12: A frame whose stop bit samples low is dropped. After such a frame, the receiver accepts the next good frame.
- R13: Words 5 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
Several properties are checked on every cycle:
- the ready bit and the zero upper bits of status, and the zero reads above word 4;
- an interrupt only when an event and an enable are both present;
- the write-one clear taking effect;
- the stop-bit completion setting the transmit event;
- the data word holding while the receive event is set;
- a high line whenever the transmitter is idle.

Other behaviour can only be shown by the bench's scenarios:
- the bit order and timing of frames on the line;
- receive refusal and framing-error drops seen at the ports;
- dropped writes while a frame is being sent;
- that the stored-only control bits have no effect.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_CTRL = 3;
  localparam int REG_DBG  = 4;

  localparam int ST_READY = 0;
  localparam int ST_RXEV  = 1;
  localparam int ST_TXEV  = 2;

  localparam int CT_RXIE  = 0;
  localparam int CT_TXIE  = 1;

  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
endpackage

// File: rtl/evt_uart_baud.sv
module evt_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == '0);
    if (restart_i)   cnt_d = '0;
    else if (tick_o) cnt_d = div_i;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_uart_tx.sv
module evt_uart_tx
  import evt_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_st_e;

  tx_st_e           st_q, st_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic [OVS_W-1:0] os_q, os_d;
  logic             txd_q, txd_d;
  logic             last_os;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    txd_d   = txd_q;
    done_o  = 1'b0;
    last_os = tick_i && (os_q == OVS_W'(OVS - 1));
    os_d    = (st_q != TX_IDLE && tick_i) ? os_q + 1'b1 : os_q;
    case (st_q)
      TX_IDLE: if (load_i) begin
        st_d  = TX_START;
        sh_d  = data_i;
        os_d  = '0;
        txd_d = 1'b0;
      end
      TX_START: if (last_os) begin
        st_d  = TX_DATA;
        bit_d = '0;
        txd_d = sh_q[0];
      end
      TX_DATA: if (last_os) begin
        if (bit_q == 3'd7) begin
          st_d  = TX_STOP;
          txd_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = sh_q >> 1;
          txd_d = sh_q[1];
        end
      end
      TX_STOP: if (last_os) begin
        st_d   = TX_IDLE;
        done_o = 1'b1;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      os_q  <= '0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      os_q  <= os_d;
      txd_q <= txd_d;
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = (st_q != TX_IDLE);
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx
  import evt_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  logic [2:0]       sync_q;
  rx_st_e           st_q, st_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic [OVS_W-1:0] os_q, os_d;
  logic             valid_q, valid_d;
  logic             line, fall, mid_start, end_bit;

  always_comb begin
    line      = sync_q[1];
    fall      = sync_q[2] & ~sync_q[1];
    mid_start = tick_i && (os_q == OVS_W'(OVS / 2 - 1));
    end_bit   = tick_i && (os_q == OVS_W'(OVS - 1));
    st_d      = st_q;
    sh_d      = sh_q;
    bit_d     = bit_q;
    valid_d   = 1'b0;
    os_d      = (st_q != RX_IDLE && tick_i) ? os_q + 1'b1 : os_q;
    case (st_q)
      RX_IDLE: if (fall) begin
        st_d = RX_START;
        os_d = '0;
      end
      RX_START: if (mid_start) begin
        st_d  = line ? RX_IDLE : RX_DATA;
        os_d  = '0;
        bit_d = '0;
      end
      RX_DATA: if (end_bit) begin
        sh_d  = {line, sh_q[7:1]};
        bit_d = bit_q + 1'b1;
        if (bit_q == 3'd7) st_d = RX_STOP;
      end
      RX_STOP: if (end_bit) begin
        valid_d = line;
        st_d    = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      st_q    <= RX_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      os_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], rxd_i};
      st_q    <= st_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      os_q    <= os_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/evt_uart.sv
module evt_uart
  import evt_uart_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             wr, wr_data, wr_div, wr_stat, wr_ctrl, wr_dbg;
  logic [7:0]       rxbuf_q, rxbuf_d;
  logic [31:0]      div_q, ctrl_q, dbg_q;
  logic             rx_evt_q, rx_evt_d, tx_evt_q, tx_evt_d;
  logic             tick, tx_load, tx_busy, tx_done, rx_valid, rx_take;
  logic [7:0]       rx_byte;
  logic             unused_bits;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr       = bus_sel & bus_we;
  assign wr_data  = wr && (word_idx == IDX_W'(REG_DATA));
  assign wr_div   = wr && (word_idx == IDX_W'(REG_DIV));
  assign wr_stat  = wr && (word_idx == IDX_W'(REG_STAT));
  assign wr_ctrl  = wr && (word_idx == IDX_W'(REG_CTRL));
  assign wr_dbg   = wr && (word_idx == IDX_W'(REG_DBG));
  assign unused_bits = ^{bus_addr[1:0], div_q[31:DIV_W]};

  evt_uart_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .restart_i(wr_div),
    .div_i(div_q[DIV_W-1:0]), .tick_o(tick)
  );

  assign tx_load = wr_data & ~tx_busy;

  evt_uart_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(tx_load),
    .data_i(bus_wdata[7:0]), .txd_o(txd), .busy_o(tx_busy), .done_o(tx_done)
  );

  evt_uart_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
    .valid_o(rx_valid), .data_o(rx_byte)
  );

  always_comb begin
    rx_take = rx_valid & ~rx_evt_q;
    rxbuf_d = rx_take ? rx_byte : rxbuf_q;
    if (rx_take)                        rx_evt_d = 1'b1;
    else if (wr_stat && bus_wdata[ST_RXEV]) rx_evt_d = 1'b0;
    else                                rx_evt_d = rx_evt_q;
    if (tx_done)                        tx_evt_d = 1'b1;
    else if (wr_stat && bus_wdata[ST_TXEV]) tx_evt_d = 1'b0;
    else                                tx_evt_d = tx_evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q  <= '0;
      div_q    <= '0;
      ctrl_q   <= '0;
      dbg_q    <= '0;
      rx_evt_q <= 1'b0;
      tx_evt_q <= 1'b0;
    end else begin
      if (rx_take) rxbuf_q <= rxbuf_d;
      if (wr_div)  div_q   <= bus_wdata;
      if (wr_ctrl) ctrl_q  <= bus_wdata;
      if (wr_dbg)  dbg_q   <= bus_wdata;
      rx_evt_q <= rx_evt_d;
      tx_evt_q <= tx_evt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word_idx)
      IDX_W'(REG_DATA): bus_rdata = {24'd0, rxbuf_q};
      IDX_W'(REG_DIV):  bus_rdata = div_q;
      IDX_W'(REG_STAT): bus_rdata = {29'd0, tx_evt_q, rx_evt_q, 1'b1};
      IDX_W'(REG_CTRL): bus_rdata = ctrl_q;
      IDX_W'(REG_DBG):  bus_rdata = dbg_q;
      default:          bus_rdata = '0;
    endcase
  end

  assign irq = (rx_evt_q & ctrl_q[CT_RXIE]) | (tx_evt_q & ctrl_q[CT_TXIE]);
endmodule

// File: rtl/evt_uart_chk.sv
module evt_uart_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-3:0] word_idx,
  input logic              clr_rx_bit,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              txd,
  input logic              rx_evt,
  input logic              tx_evt,
  input logic              ctrl_rxie,
  input logic              ctrl_txie,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              rx_valid,
  input logic [7:0]        rx_byte
);
  logic stat_sel, stat_clr_rx;
  assign stat_sel    = (word_idx == (ADDR_W-2)'(2));
  assign stat_clr_rx = bus_sel && bus_we && stat_sel && clr_rx_bit;

  a_r3_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> (bus_rdata[0] && bus_rdata[31:3] == 29'd0));
  a_r5_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_evt || tx_evt));
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_rxie || ctrl_txie));
  a_r6_clear_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_rx && !rx_valid) |=> !rx_evt);
  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r8_done_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> tx_evt);
  a_r11_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && !stat_clr_rx) |=> $stable(rx_byte));
  a_r13_high_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx > (ADDR_W-2)'(4)) |-> (bus_rdata == 32'd0));
endmodule

bind evt_uart evt_uart_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .word_idx(bus_addr[ADDR_W-1:2]), .clr_rx_bit(bus_wdata[1]),
  .bus_rdata(bus_rdata), .irq(irq), .txd(txd),
  .rx_evt(rx_evt_q), .tx_evt(tx_evt_q),
  .ctrl_rxie(ctrl_q[0]), .ctrl_txie(ctrl_q[1]),
  .tx_busy(tx_busy), .tx_done(tx_done),
  .rx_valid(rx_valid), .rx_byte(rxbuf_q)
);

// File: tb/evt_uart_tb_top.sv
module evt_uart_tb_top;
  localparam int ADDR_W = 5;
  localparam int DIV    = 1;
  localparam int BIT    = 16 * (DIV + 1);

  logic              clk, rst_n, bus_sel, bus_we, rxd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              irq, txd;
  int                checks = 0;
  int                fails  = 0;

  evt_uart #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] exp_stat(input logic rxe, input logic txe);
    return {29'd0, txe, rxe, 1'b1};
  endfunction

  function automatic logic exp_irq(input logic rxe, input logic txe, input logic [31:0] ctl);
    return (rxe & ctl[0]) | (txe & ctl[1]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int word, input logic [31:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1;
    bus_addr = ADDR_W'(word * 4); bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic peek(input int word, output logic [31:0] val);
    bus_addr = ADDR_W'(word * 4);
    #1 val = bus_rdata;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic decode_tx(output logic [7:0] b, output logic stop, output logic [31:0] st_mid);
    int guard = 0;
    while (txd !== 1'b0 && guard < 4 * BIT) begin
      @(negedge clk); guard++;
    end
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      b[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    stop = txd;
    peek(2, st_mid);
  endtask

  logic [31:0] v, ctl, r;
  logic [7:0]  b, got, keep;
  logic        stp;

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rxd = 1'b1;
    v = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 word map
    peek(0, r); chk("R1 data", r, 32'd0);
    peek(1, r); chk("R1 div", r, 32'd0);
    peek(2, r); chk("R1 status", r, 32'h1);
    peek(3, r); chk("R1 ctrl", r, 32'd0);
    peek(4, r); chk("R1 dbg", r, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 txd", {31'd0, txd}, 32'd1);

    // R4 full-width storage with random values; events are clear so irq must stay low
    for (int k = 0; k < 6; k++) begin
      v = $urandom(); bus_write(1, v); peek(1, r); chk("R4 div readback", r, v);
      v = $urandom(); bus_write(3, v); peek(3, r); chk("R4 ctrl readback", r, v);
      chk("R5 irq without event", {31'd0, irq}, 32'd0);
      v = $urandom(); bus_write(4, v); peek(4, r); chk("R4 dbg readback", r, v);
      peek(2, r); chk("R3 status idle", r, exp_stat(1'b0, 1'b0));
      chk("R4 txd unaffected", {31'd0, txd}, 32'd1);
    end
    bus_write(1, DIV);
    ctl = 32'h0000_0004;  // pass-through bit set: must not affect anything
    bus_write(3, ctl);
    bus_write(4, 32'h1);  // break bit set: must not affect anything

    // R7, R8 random transmit bytes
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom());
      bus_write(0, {24'($urandom()), b});
      peek(2, r); chk("R8 no event at write", r, exp_stat(1'b0, 1'b0));
      decode_tx(got, stp, r);
      chk("R7 tx byte", {24'd0, got}, {24'd0, b});
      chk("R7 stop bit", {31'd0, stp}, 32'd1);
      chk("R8 no event mid stop", r, exp_stat(1'b0, 1'b0));
      repeat (BIT) @(negedge clk);
      peek(2, r); chk("R8 event after stop", r, exp_stat(1'b0, 1'b1));
      chk("R5 irq tx disabled", {31'd0, irq}, 32'd0);
      ctl = 32'h2; bus_write(3, ctl);
      chk("R5 irq tx enabled", {31'd0, irq}, {31'd0, exp_irq(1'b0, 1'b1, ctl)});
      ctl = 32'h1; bus_write(3, ctl);
      chk("R5 irq wrong enable", {31'd0, irq}, {31'd0, exp_irq(1'b0, 1'b1, ctl)});
      bus_write(2, 32'hFFFF_FFF9);
      peek(2, r); chk("R6 other ones ignored", r, exp_stat(1'b0, 1'b1));
      bus_write(2, 32'h4);
      peek(2, r); chk("R6 clear tx event", r, exp_stat(1'b0, 1'b0));
      ctl = 32'h0; bus_write(3, ctl);
    end

    // R9 write while busy is dropped
    b = 8'hA5;
    bus_write(0, {24'd0, b});
    bus_write(0, 32'h0000_003C);
    decode_tx(got, stp, r);
    chk("R9 first byte sent", {24'd0, got}, {24'd0, b});
    begin
      int lows = 0;
      for (int i = 0; i < 3 * BIT; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) lows++;
      end
      chk("R9 no second frame", lows, 0);
    end
    bus_write(2, 32'h4);

    // R10 random receive bytes with interrupt
    ctl = 32'h1; bus_write(3, ctl);
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom());
      send_frame(b, 1'b1);
      peek(0, r); chk("R10 rx data", r, {24'd0, b});
      peek(2, r); chk("R10 rx event", r, exp_stat(1'b1, 1'b0));
      chk("R5 irq rx", {31'd0, irq}, {31'd0, exp_irq(1'b1, 1'b0, ctl)});
      bus_write(2, 32'h2);
      peek(2, r); chk("R6 clear rx event", r, exp_stat(1'b0, 1'b0));
      chk("R5 irq after clear", {31'd0, irq}, 32'd0);
      keep = b;
    end

    // R11 refusal while event set
    send_frame(8'h5A, 1'b1);
    keep = 8'h5A;
    send_frame(8'hC3, 1'b1);
    peek(0, r); chk("R11 data held", r, {24'd0, keep});
    peek(2, r); chk("R11 event still set", r, exp_stat(1'b1, 1'b0));
    bus_write(2, 32'h2);
    send_frame(8'h96, 1'b1);
    peek(0, r); chk("R11 accepted after clear", r, 32'h96);
    bus_write(2, 32'h2);

    // R12 framing error dropped, then recovery
    send_frame(8'h7E, 1'b0);
    peek(0, r); chk("R12 data unchanged", r, 32'h96);
    peek(2, r); chk("R12 no event", r, exp_stat(1'b0, 1'b0));
    send_frame(8'h18, 1'b1);
    peek(0, r); chk("R12 recovery byte", r, 32'h18);
    bus_write(2, 32'h2);

    // R13 high words read zero, writes ignored
    for (int w = 5; w < 8; w++) begin
      bus_write(w, 32'hFFFF_FFFF);
      peek(w, r); chk("R13 high word zero", r, 32'd0);
    end
    peek(1, r); chk("R13 div untouched", r, DIV);
    peek(3, r); chk("R13 ctrl untouched", r, ctl);
    peek(4, r); chk("R13 dbg untouched", r, 32'h1);
    peek(2, r); chk("R13 status untouched", r, exp_stat(1'b0, 1'b0));
    chk("R13 line idle", {31'd0, txd}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule